// File: doc/BRIEF.md
# CIC Droop Compensation Decimator

This block sits after a fourth-order CIC decimator in a sigma-delta converter's decimation chain. It takes a stream of signed samples, each marked by a valid strobe, and filters them with an 11-tap linear-phase FIR. The FIR's gain rises across the passband to cancel the sinc^4 droop of a CIC that decimates by 32. It keeps every second filtered sample, so the output rate is half the input rate. For example, a 192 kHz input stream gives a 96 kHz output stream.

The taps are split into two polyphase branches. Even-indexed input samples fill one delay line and odd-indexed samples fill the other, so each branch shifts at the output rate. Mirrored taps sit in the same branch, which lets them be summed before weighting. Each of the six distinct coefficients is applied as a short sum of shifted, signed copies of that pre-added value. The shifts come from compile-time signed-power-of-two lists, and the block has no general multiplier. The sum is kept at full width, then rounded and saturated to the output width.

Top module: `cic_comp_decim`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is low and `out_data` is zero.
- R2: A cycle with `in_valid` low changes nothing. `out_valid` stays low and `out_data` keeps its last value, whatever is on `in_data`.
- R3: Accepted samples are numbered 0, 1, 2, ... from reset. An output can appear only when an odd-numbered sample is accepted. In that case `out_valid` is high for exactly one cycle, the cycle after the accepting clock edge, and `out_data` changes in that same cycle.
- R4: Samples 0 to 10 produce no output. The first output follows sample 11, and later outputs follow samples 13, 15, and so on.
- R5: The output for sample n is round(sum over k of h[k]·x[n−k] / 1024). The taps h[0..10] are −2, 8, −22, 48, −224, 1408, −224, 48, −22, 8, −2, which is symmetric with 10 fractional bits.
- R6: Rounding is to nearest, with ties going toward positive infinity. In formula form, the result is floor((acc + 512) / 1024).
- R7: A rounded result above 2^(OW−1)−1 gives 2^(OW−1)−1. A result below −2^(OW−1) gives −2^(OW−1).
- R8: The tap sum is exactly 1024. Once the delay line is full, a constant input A therefore gives outputs exactly equal to A.
- R9: A synchronous reset in the middle of a stream, including one after an odd number of accepted samples, restarts the numbering. No output appears until sample 11 after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | IW | Signed input sample from the CIC |
| out_valid | output | 1 | One-cycle strobe for a new output |
| out_data | output | OW | Signed, rounded, saturated output sample |

## Verification
Each input is driven on a falling clock edge and captured on the next rising edge. A result for an odd-numbered sample is therefore registered at that same rising edge. The bench compares `out_valid` and `out_data` with its model on the falling edge that follows. This happens every cycle, including idle cycles, so early, late and stray strobes are caught along with wrong values. The reference model is an 11-sample window convolved with the tap list, and it decides the due cycle purely from the accepted-sample count since reset.

// File: rtl/cic_comp_decim.sv
module cic_comp_decim #(
  parameter int IW    = 16,
  parameter int OW    = 16,
  parameter int FRAC  = 10,
  parameter int NUNIQ = 6,
  parameter int NTERM = 4,
  parameter int SG [NUNIQ][NTERM] = '{'{-1,0,0,0}, '{1,0,0,0}, '{-1,1,1,0},
                                     '{1,-1,0,0}, '{-1,1,0,0}, '{1,1,-1,0}},
  parameter int SH [NUNIQ][NTERM] = '{'{1,0,0,0}, '{3,0,0,0}, '{5,3,1,0},
                                     '{6,4,0,0}, '{8,5,0,0}, '{10,9,7,0}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);

  localparam int NTAP = 2*NUNIQ - 1;
  localparam int NA   = NUNIQ - 1;
  localparam int NB   = NUNIQ - 1;
  localparam int AW   = IW + FRAC + 4;
  localparam int CW   = $clog2(NUNIQ);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC-1);
  localparam logic signed [AW-1:0] OMAX = AW'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

  logic signed [IW-1:0] ra [NA];
  logic signed [IW-1:0] rb [NB];
  logic signed [IW-1:0] tapv [NTAP];
  logic signed [AW-1:0] pre [NUNIQ];
  logic signed [AW-1:0] acc, rnd;
  logic signed [OW-1:0] sat;
  logic                 phase;
  logic [CW-1:0]        fill;

  wire take_even = in_valid && !phase;
  wire take_odd  = in_valid && phase;
  wire fire      = take_odd && (fill == CW'(NUNIQ-1));

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_live
      assign tapv[k] = in_data;
    end else if (k % 2 == 0) begin : g_even
      assign tapv[k] = rb[k/2 - 1];
    end else begin : g_odd
      assign tapv[k] = ra[(k-1)/2];
    end
  end

  for (genvar j = 0; j < NUNIQ; j++) begin : g_pre
    if (j == NUNIQ-1) begin : g_mid
      assign pre[j] = AW'(tapv[j]);
    end else begin : g_pair
      assign pre[j] = AW'(tapv[j]) + AW'(tapv[NTAP-1-j]);
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < NUNIQ; j++)
      for (int t = 0; t < NTERM; t++)
        if (SG[j][t] > 0)      acc = acc + (pre[j] <<< SH[j][t]);
        else if (SG[j][t] < 0) acc = acc - (pre[j] <<< SH[j][t]);
  end

  assign rnd = (acc + HALF) >>> FRAC;
  assign sat = (rnd > OMAX) ? OMAX[OW-1:0] :
               (rnd < OMIN) ? OMIN[OW-1:0] : rnd[OW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NA; i++) ra[i] <= '0;
      for (int i = 0; i < NB; i++) rb[i] <= '0;
      phase     <= 1'b0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (in_valid) phase <= !phase;
      if (take_even) begin
        ra[0] <= in_data;
        for (int i = 1; i < NA; i++) ra[i] <= ra[i-1];
      end
      if (take_odd) begin
        rb[0] <= in_data;
        for (int i = 1; i < NB; i++) rb[i] <= rb[i-1];
        if (fill != CW'(NUNIQ-1)) fill <= fill + 1'b1;
      end
      if (fire) out_data <= sat;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);  // R3
  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));  // R3
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && !out_valid));  // R2
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));  // R1

endmodule

// File: tb/cic_comp_decim_tb.sv
module cic_comp_decim_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  always #10 clk = ~clk;

  cic_comp_decim u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    checks = 0;
  int    fails  = 0;
  string req    = "R1";
  longint win [11];
  int    nacc;
  bit    exp_valid;
  longint exp_data;
  bit    done = 1'b0;

  function automatic longint coef(int k);
    case (k)
      0, 10: return -2;
      1, 9:  return 8;
      2, 8:  return -22;
      3, 7:  return 48;
      4, 6:  return -224;
      default: return 1408;
    endcase
  endfunction

  function automatic longint expect_out();
    longint a = 0;
    longint r;
    for (int k = 0; k < 11; k++) a += coef(k) * win[k];
    r = (a + 512) >>> 10;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 11; k++) win[k] = 0;
    nacc = 0; exp_valid = 0; exp_data = 0;
  endtask

  task automatic check();
    checks++;
    if (out_valid !== exp_valid || longint'(out_data) != exp_data) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               req, out_valid, out_data, exp_valid, exp_data);
    end
  endtask

  task automatic step(bit v, logic signed [15:0] d);
    in_valid = v; in_data = d;
    exp_valid = 0;
    if (v) begin
      for (int k = 10; k > 0; k--) win[k] = win[k-1];
      win[0] = longint'(d);
      if (nacc % 2 == 1 && nacc >= 11) begin
        exp_valid = 1; exp_data = expect_out();
      end
      nacc++;
    end
    @(negedge clk);
    check();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    model_reset();
    @(negedge clk);
    req = "R1"; check();
    @(negedge clk);
    check();
    rst = 1'b0;
    @(negedge clk);
    check();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();

    // DC: fill behaviour then unity gain
    for (int i = 0; i < 40; i++) begin
      req = (i < 12) ? "R4" : "R8";
      step(1'b1, 16'sd1000);
    end
    for (int i = 0; i < 20; i++) begin req = "R8"; step(1'b1, -16'sd30000); end

    // Impulse response
    do_reset();
    req = "R4";
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd0);
    req = "R5";
    step(1'b1, 16'sd1024);
    for (int i = 0; i < 14; i++) step(1'b1, 16'sd0);

    // Rounding ties and small magnitudes
    req = "R6";
    step(1'b1, 16'sd64);
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd0);
    step(1'b1, -16'sd64);
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd0);
    step(1'b1, 16'sd3);
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd0);

    // Idle cycles with garbage data
    req = "R2";
    for (int i = 0; i < 12; i++) step(1'b0, 16'($urandom));
    step(1'b1, 16'sd500);
    for (int i = 0; i < 6; i++) step(1'b0, 16'($urandom));
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd500);

    // Saturation both directions
    req = "R7";
    for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? -16'sd32768 : 16'sd32767);
    for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 16'sd32767 : -16'sd32768);

    // Random stream with gaps
    req = "R3";
    for (int i = 0; i < 2000; i++) begin
      bit v = ($urandom % 10) < 7;
      step(v, 16'($urandom));
    end

    // Mid-stream reset after odd count
    req = "R9";
    for (int i = 0; i < 7; i++) step(1'b1, 16'($urandom));
    do_reset();
    req = "R9";
    for (int i = 0; i < 30; i++) step(1'b1, 16'($urandom % 20000) - 16'sd10000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule